// File: doc/BRIEF.md
# DAC Serial Frame Sender

This block drives a serial digital-to-analog converter from the host side. It accepts a conversion code and a two-bit operating mode over a valid/ready handshake. It assembles a 24-bit word and shifts it out as three contiguous bytes, most significant bit first, inside one active-low sync window. It derives the serial clock from the system clock by counting a fixed number of system cycles per clock phase.

The serial clock idles low. Data changes on each rising edge, so the converter samples it on the falling edge. A lead phase separates the fall of sync from the first rising edge, and a tail phase separates the 24th falling edge from the rise of sync. After every frame, sync stays high for a programmed gap before the next command is taken. An abort input raises sync at once in the middle of a frame, and the converter then discards the write.

The defaults assume a 200 MHz system clock: each clock phase lasts 20 ns, giving a 25 MHz serial clock, and the minimum sync-high time is 45 ns. An elaboration check rejects parameter sets that break the phase-width, clock-rate or gap limits.

Top module: `dac_frame_sender`

## Requirements
- R1: Out of reset and whenever idle, sync is high, serial clock and data are low, busy is low and ready is high.
- R2: The word carries zeros in bits 23:18, the mode in bits 17:16 and the code in bits 15:0. A code narrower than 16 bits is left-aligned and padded with zeros below it.
- R3: Word bits leave in order from bit 23 down to bit 0. Bits 23:16 form the first byte, 15:8 the second and 7:0 the third, with no pause between bytes.
- R4: A completed frame has exactly 24 falling serial clock edges inside a single sync-low window.
- R5: During a frame, every high phase and every low phase of the serial clock lasts exactly HALF_CYC system cycles.
- R6: The first rising edge comes HALF_CYC cycles after sync falls. Sync rises HALF_CYC cycles after the 24th falling edge.
- R7: Sync stays high for at least GAP_CYC+1 cycles between frames, and for exactly that long when a command is already waiting.
- R8: Ready is high only when idle, and a command is taken on a cycle with valid and ready both high. Busy is high from the cycle after acceptance until the gap ends. A command held while busy is sent exactly once.
- R9: Abort during a frame drives sync high and clock and data low on the next cycle, and the gap follows. Abort while idle has no effect.
- R10: Data changes only together with a rising serial clock edge, or by returning low when sync rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Command can be taken |
| cmd_code_i | input | CODE_W | Conversion code |
| cmd_mode_i | input | 2 | Operating mode placed in bits 17:16 |
| abort_i | input | 1 | Cancel the frame in progress |
| sync_n_o | output | 1 | Active-low frame sync |
| sclk_o | output | 1 | Serial clock, idle low |
| sdo_o | output | 1 | Serial data, changes on rising clock |
| busy_o | output | 1 | Frame or gap in progress |

## Verification
The hardest cases to reach are the precise sync-high gap when a command is already waiting, and an abort that lands partway through a byte. Both depend on what the host does at an exact cycle relative to the frame. The driver holds valid high across consecutive commands, so the next frame starts on the first legal cycle and the monitor can measure the shortest gap. Aborts are issued at fixed delays after acceptance: one inside the lead phase, one in the middle of the first byte and one in the second byte. The next cycle is checked for a released sync, and the monitor confirms that fewer than 24 bits were clocked.

// File: rtl/dfs_pkg.sv
`timescale 1ns/1ps
package dfs_pkg;
  localparam int FRAME_W    = 24;
  localparam int BYTE_W     = 8;
  localparam int N_BYTES    = FRAME_W / BYTE_W;
  localparam int DATA_W     = 16;
  localparam int MODE_W     = 2;
  localparam int PAD_W      = FRAME_W - MODE_W - DATA_W;
  localparam int BIT_IDX_W  = $clog2(BYTE_W);
  localparam int BYTE_IDX_W = $clog2(N_BYTES);

  typedef logic [BYTE_W-1:0] byte_t;
  typedef byte_t [N_BYTES-1:0] frame_t;  // index N_BYTES-1 leaves first

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TAIL,
    ST_GAP
  } tx_state_e;
endpackage

// File: rtl/dfs_frame_pack.sv
`timescale 1ns/1ps
module dfs_frame_pack
  import dfs_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [MODE_W-1:0] mode_i,
  output frame_t            frame_o
);
  logic [DATA_W-1:0] data_al;

  generate
    if (CODE_W == DATA_W) begin : g_full
      assign data_al = code_i;
    end else begin : g_pad
      assign data_al = {code_i, {(DATA_W-CODE_W){1'b0}}};
    end
  endgenerate

  assign frame_o = {{PAD_W{1'b0}}, mode_i, data_al};
endmodule

// File: rtl/dfs_cycle_timer.sv
`timescale 1ns/1ps
module dfs_cycle_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;

  assign done_o = en_i && (cnt_q == CW'(LIMIT-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || done_o)  cnt_q <= '0;
    else if (en_i)             cnt_q <= cnt_q + 1'b1;
  end

  a_r5_timer_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !clr_i && !done_o |=> cnt_q != '0);
endmodule

// File: rtl/dfs_bit_seq.sv
`timescale 1ns/1ps
module dfs_bit_seq
  import dfs_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic                  step_i,
  output logic [BIT_IDX_W-1:0]  bit_o,
  output logic [BYTE_IDX_W-1:0] byte_o,
  output logic                  last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_o  <= '0;
      byte_o <= '0;
    end else if (load_i) begin
      bit_o  <= '0;
      byte_o <= '0;
    end else if (step_i) begin
      if (bit_o == BIT_IDX_W'(BYTE_W-1)) begin
        bit_o  <= '0;
        byte_o <= byte_o + 1'b1;
      end else begin
        bit_o  <= bit_o + 1'b1;
      end
    end
  end

  assign last_o = (byte_o == BYTE_IDX_W'(N_BYTES-1)) && (bit_o == BIT_IDX_W'(BYTE_W-1));

  // R4: never advance beyond the final bit of the word
  a_r4_step_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> !last_o);
endmodule

// File: rtl/dac_frame_sender.sv
`timescale 1ns/1ps
module dac_frame_sender
  import dfs_pkg::*;
#(
  parameter int CODE_W      = 16,
  parameter int HALF_CYC    = 4,
  parameter int GAP_CYC     = 8,
  parameter int SYS_CLK_MHZ = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [CODE_W-1:0] cmd_code_i,
  input  logic [1:0]        cmd_mode_i,
  input  logic              abort_i,
  output logic              sync_n_o,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              busy_o
);
  localparam longint HALF_PS = longint'(HALF_CYC) * 1000000 / SYS_CLK_MHZ;
  localparam longint GAP_PS  = longint'(GAP_CYC + 1) * 1000000 / SYS_CLK_MHZ;

  generate
    if (HALF_PS < 13000 || 2*HALF_PS < 33334 || GAP_PS < 33000 || CODE_W > DATA_W || GAP_CYC < 1)
    begin : g_bad_cfg
      $error("dac_frame_sender: timing parameters out of range");
    end
  endgenerate

  tx_state_e state_q;
  frame_t    frame_d, frame_q;
  logic      sync_n_q, sclk_q, sdo_q;
  logic      half_done, gap_done, active, cur_bit;
  logic [BIT_IDX_W-1:0]  bit_idx;
  logic [BYTE_IDX_W-1:0] byte_idx;
  logic      seq_last, seq_step;

  assign active = (state_q == ST_LEAD) || (state_q == ST_SHIFT) || (state_q == ST_TAIL);

  dfs_frame_pack #(.CODE_W(CODE_W)) u_pack (
    .code_i  (cmd_code_i),
    .mode_i  (cmd_mode_i),
    .frame_o (frame_d)
  );

  dfs_cycle_timer #(.LIMIT(HALF_CYC)) u_half_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!active),
    .en_i   (active),
    .done_o (half_done)
  );

  dfs_cycle_timer #(.LIMIT(GAP_CYC)) u_gap_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q != ST_GAP),
    .en_i   (state_q == ST_GAP),
    .done_o (gap_done)
  );

  // advance on each falling edge except the last
  assign seq_step = (state_q == ST_SHIFT) && half_done && sclk_q && !seq_last && !abort_i;

  dfs_bit_seq u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (state_q == ST_IDLE),
    .step_i (seq_step),
    .bit_o  (bit_idx),
    .byte_o (byte_idx),
    .last_o (seq_last)
  );

  assign cur_bit = frame_q[BYTE_IDX_W'(N_BYTES-1) - byte_idx][BIT_IDX_W'(BYTE_W-1) - bit_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      frame_q  <= '0;
      sync_n_q <= 1'b1;
      sclk_q   <= 1'b0;
      sdo_q    <= 1'b0;
    end else if (active && abort_i) begin
      sync_n_q <= 1'b1;
      sclk_q   <= 1'b0;
      sdo_q    <= 1'b0;
      state_q  <= ST_GAP;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cmd_valid_i) begin
          frame_q  <= frame_d;
          sync_n_q <= 1'b0;
          state_q  <= ST_LEAD;
        end
        ST_LEAD: if (half_done) begin
          sclk_q  <= 1'b1;
          sdo_q   <= cur_bit;
          state_q <= ST_SHIFT;
        end
        ST_SHIFT: if (half_done) begin
          if (sclk_q) begin
            sclk_q <= 1'b0;
            if (seq_last) state_q <= ST_TAIL;
          end else begin
            sclk_q <= 1'b1;
            sdo_q  <= cur_bit;
          end
        end
        ST_TAIL: if (half_done) begin
          sync_n_q <= 1'b1;
          sdo_q    <= 1'b0;
          state_q  <= ST_GAP;
        end
        ST_GAP: if (gap_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sync_n_o    = sync_n_q;
  assign sclk_o      = sclk_q;
  assign sdo_o       = sdo_q;
  assign cmd_ready_o = (state_q == ST_IDLE);
  assign busy_o      = (state_q != ST_IDLE);

  // checker counters
  logic [15:0] lo_cnt, hi_cnt, shi_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt  <= '0;
      hi_cnt  <= '0;
      shi_cnt <= 16'(GAP_CYC + 1);
    end else begin
      lo_cnt  <= (sync_n_q || sclk_q)  ? '0 : (lo_cnt == '1 ? lo_cnt : lo_cnt + 1'b1);
      hi_cnt  <= (sync_n_q || !sclk_q) ? '0 : (hi_cnt == '1 ? hi_cnt : hi_cnt + 1'b1);
      shi_cnt <= !sync_n_q ? '0 : (shi_cnt == '1 ? shi_cnt : shi_cnt + 1'b1);
    end
  end

  a_r1_idle_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> (sync_n_o && !sclk_o && !sdo_o && !busy_o));

  a_r5_low_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_q) |-> lo_cnt == 16'(HALF_CYC));

  a_r5_high_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sclk_q) && !sync_n_q) |-> hi_cnt == 16'(HALF_CYC));

  a_r7_sync_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_n_q) |-> shi_cnt >= 16'(GAP_CYC + 1));

  a_r8_accept_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_n_q) |-> $past(cmd_valid_i && cmd_ready_o));

  a_r9_abort_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && abort_i) |=> (sync_n_q && !sclk_q && !sdo_q && busy_o));

  a_r10_sdo_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(sdo_q) |-> ($rose(sclk_q) || $rose(sync_n_q)));
endmodule

// File: tb/dac_frame_sender_tb.sv
`timescale 1ns/1ps
module dac_frame_sender_tb;
  localparam int CODE_W = 16;
  localparam int HALF   = 4;
  localparam int GAP    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic [CODE_W-1:0] cmd_code = '0;
  logic [1:0]        cmd_mode = '0;
  logic              abort = 1'b0;
  logic              sync_n, sclk, sdo, busy;

  dac_frame_sender #(.CODE_W(CODE_W), .HALF_CYC(HALF), .GAP_CYC(GAP)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cmd_valid_i (cmd_valid),
    .cmd_ready_o (cmd_ready),
    .cmd_code_i  (cmd_code),
    .cmd_mode_i  (cmd_mode),
    .abort_i     (abort),
    .sync_n_o    (sync_n),
    .sclk_o      (sclk),
    .sdo_o       (sdo),
    .busy_o      (busy)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [23:0] frame;
    bit          aborted;
  } exp_t;
  exp_t exp_q[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  // driver: called and returns at a falling clock edge
  task automatic send(input logic [15:0] code, input logic [1:0] mode,
                      input bit ab, input int ab_delay);
    exp_t e;
    e.frame   = {6'b0, mode, code};
    e.aborted = ab;
    exp_q.push_back(e);
    cmd_valid = 1'b1;
    cmd_code  = code;
    cmd_mode  = mode;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy && !cmd_ready, "R8 busy after accept", {busy, cmd_ready}, 2'b10);
    if (ab) begin
      repeat (ab_delay) @(negedge clk);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      chk(sync_n && !sclk && !sdo && busy, "R9 abort release",
          {sync_n, sclk, sdo, busy}, 4'b1001);
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // monitor
  logic        p_sync = 1'b1, p_sclk = 1'b0, p_sdo = 1'b0;
  logic [23:0] bits = '0;
  int          nbits = 0, run = 0, hi_run = 0, min_gap = 1000;
  bit          seen_frame = 0;
  exp_t        m_e;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!sync_n) begin
        if (p_sync) begin
          if (seen_frame) begin
            chk(hi_run >= GAP + 1, "R7 sync high gap", hi_run, GAP + 1);
            if (hi_run < min_gap) min_gap = hi_run;
          end
          nbits = 0;
          bits  = '0;
          run   = 1;
        end else begin
          if (sclk && !p_sclk) begin
            if (nbits == 0) chk(run == HALF, "R6 lead phase", run, HALF);
            else if (run != HALF) chk(0, "R5 low phase", run, HALF);
            run = 1;
          end else if (!sclk && p_sclk) begin
            if (run != HALF) chk(0, "R5 high phase", run, HALF);
            bits  = {bits[22:0], sdo};
            nbits = nbits + 1;
            run   = 1;
          end else begin
            run = run + 1;
          end
          if (sdo != p_sdo && !(sclk && !p_sclk))
            chk(0, "R10 data moved off rising edge", sdo, p_sdo);
        end
      end else if (!p_sync) begin
        if (exp_q.size() == 0) begin
          chk(0, "R8 unexpected frame", bits, 0);
        end else begin
          m_e = exp_q.pop_front();
          if (m_e.aborted) begin
            chk(nbits < 24, "R9 aborted frame short", nbits, 23);
          end else begin
            chk(nbits == 24, "R4 falling edge count", nbits, 24);
            chk(bits == m_e.frame, "R2 R3 word content", bits, m_e.frame);
            chk(run == HALF, "R6 tail phase", run, HALF);
          end
        end
        chk(busy && !sclk && !sdo, "R8 busy through gap", {busy, sclk, sdo}, 3'b100);
        hi_run     = 1;
        seen_frame = 1;
      end else begin
        hi_run = hi_run + 1;
      end
      p_sync = sync_n;
      p_sclk = sclk;
      p_sdo  = sdo;
    end
  end

  bit timed_out = 0;

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        chk(sync_n && !sclk && !sdo && !busy && cmd_ready, "R1 reset state",
            {sync_n, sclk, sdo, busy, cmd_ready}, 5'b10001);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sync_n && !sclk && !sdo && !busy && cmd_ready, "R1 idle after reset",
            {sync_n, sclk, sdo, busy, cmd_ready}, 5'b10001);
        // abort while idle is ignored
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        @(negedge clk);
        chk(sync_n && !busy && cmd_ready, "R9 idle abort ignored",
            {sync_n, busy, cmd_ready}, 3'b101);
        // single frames with distinct patterns
        send(16'hFFFF, 2'b11, 0, 0);  wait_idle();
        send(16'h0000, 2'b00, 0, 0);  wait_idle();
        send(16'hA5C3, 2'b01, 0, 0);  wait_idle();
        @(negedge clk);
        chk(sync_n && !sclk && !sdo && cmd_ready, "R1 idle between frames",
            {sync_n, sclk, sdo, cmd_ready}, 4'b1001);
        // back-to-back: valid held while busy
        send(16'h1234, 2'b10, 0, 0);
        send(16'h8001, 2'b00, 0, 0);
        send(16'h7FFE, 2'b01, 0, 0);
        wait_idle();
        // aborts: in lead, mid first byte, in second byte
        send(16'hBEEF, 2'b11, 1, 0);   wait_idle();
        send(16'hC0DE, 2'b10, 1, 30);  wait_idle();
        send(16'h5A5A, 2'b01, 1, 90);  wait_idle();
        // normal frame after aborts
        send(16'h0F0F, 2'b10, 0, 0);   wait_idle();
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R8 every command sent once", exp_q.size(), 0);
        chk(min_gap == GAP + 1, "R7 shortest gap", min_gap, GAP + 1);
        chk(cmd_ready && !busy && sync_n, "R1 final idle", {cmd_ready, busy, sync_n}, 3'b101);
      end
      begin
        repeat (100000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) chk(0, "watchdog expired", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule